// File: doc/BRIEF.md
# Shared Register Window with Layered Defaults

This block is a small register window that lives inside a device BAR and is shared by two parties. The host reaches it through a simple read/write bus with a byte offset and per-byte enables. Device-side firmware reaches it through a word-indexed control port that can either snapshot a word or overwrite it. Every host write stores its data and marks the touched word as dirty. A level event output stays high while any word is dirty, which tells the device side that the host has written something it has not yet looked at.

Each word's read value comes from a priority chain. The last value written by either side comes first. If no value has been written, the active per-device default is used, then the per-type default, and finally zero. Per-device defaults are staged and only become active on a function-level reset. Per-type defaults may only change while no device instance exists. The device side clears a dirty word by querying or overwriting exactly that word. If it leaves any dirty word untouched, the event stays raised, so the notification fires again.

The window is sized as a whole number of 64-byte blocks, with four blocks by default (64 words of 32 bits). Both read ports return data one cycle after the request.

Top module: `stateful_bar_region`

## Requirements
- R1: After power-on reset, every word reads as zero, `wr_event` is low and `tdef_reject` is low.
- R2: A host write with all byte enables set stores the data at word `host_addr[AW-1:2]`. A host read issued in the very next cycle returns it, with `host_rvalid` high one cycle after `host_rd`.
- R3: A host write changes only the bytes whose `host_be` bit is set (bit i covers data bits 8i+7..8i). The other bytes keep the word's current resolved value.
- R4: Every host write marks its word dirty, and `wr_event` is high one cycle later. It stays high while any word is dirty.
- R5: A device query returns the word's resolved value on `ctl_rdata` one cycle later, with `ctl_rvalid` high. The query clears only that word's dirty mark, so `wr_event` stays high while another written word is still unqueried.
- R6: A device modify replaces the word's value, clears its dirty mark, and is then what the host reads back.
- R7: A word's value resolves as: last written value, else active per-device default, else per-type default, else zero.
- R8: A staged per-device default has no effect on reads until the next `flr` pulse.
- R9: An `flr` pulse discards all written values and dirty marks, so `wr_event` goes low. It activates the staged per-device defaults and keeps the per-type defaults.
- R10: A per-type default write while `dev_present` is high is dropped, and `tdef_reject` pulses one cycle later. With `dev_present` low, the write is taken.
- R11: When a host write and a device modify hit the same word in the same cycle, the host data is kept and the word stays dirty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset, clears every layer |
| flr | input | 1 | Function-level reset pulse |
| dev_present | input | 1 | A device instance of this type exists |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | AW | Host byte offset inside the window |
| host_be | input | DW/8 | Host byte enables |
| host_wdata | input | DW | Host write data |
| host_rdata | output | DW | Host read data |
| host_rvalid | output | 1 | Host read data valid |
| ctl_query | input | 1 | Device-side snapshot of one word |
| ctl_modify | input | 1 | Device-side overwrite of one word |
| ctl_word | input | WW | Device-side word index |
| ctl_wdata | input | DW | Device-side overwrite data |
| ctl_rdata | output | DW | Device-side snapshot data |
| ctl_rvalid | output | 1 | Device-side snapshot valid |
| tdef_wr | input | 1 | Per-type default write |
| tdef_word | input | WW | Per-type default word index |
| tdef_data | input | DW | Per-type default value |
| tdef_reject | output | 1 | Per-type default write was refused |
| ddef_wr | input | 1 | Staged per-device default write |
| ddef_word | input | WW | Staged per-device default word index |
| ddef_data | input | DW | Staged per-device default value |
| wr_event | output | 1 | Some host-written word is still unhandled |

## Verification
Reads are tried on words in four states: untouched, carrying only a per-type default, carrying an active per-device default, and written. This shows that each layer of the priority chain wins only when the layers above it are empty. Partial byte-enable writes over both a zero word and a written word show whether the merge uses the resolved value or stale storage. The event is observed while two words are dirty and only one is queried, which separates per-word tracking from a single global flag. Finally, a same-cycle host write and device modify on one word, and a type-default write attempted with a device present, cover the ordering and rejection paths.

// File: rtl/stateful_bar_region.sv
module stateful_bar_region #(
  parameter int NUM_BLOCKS  = 4,
  parameter int BLOCK_BYTES = 64,
  parameter int DW          = 32,
  localparam int BE_W         = DW / 8,
  localparam int REGION_BYTES = NUM_BLOCKS * BLOCK_BYTES,
  localparam int WORDS        = REGION_BYTES / BE_W,
  localparam int AW           = $clog2(REGION_BYTES),
  localparam int WW           = $clog2(WORDS),
  localparam int LSB          = $clog2(BE_W)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flr,
  input  logic            dev_present,
  input  logic            host_wr,
  input  logic            host_rd,
  input  logic [AW-1:0]   host_addr,
  input  logic [BE_W-1:0] host_be,
  input  logic [DW-1:0]   host_wdata,
  output logic [DW-1:0]   host_rdata,
  output logic            host_rvalid,
  input  logic            ctl_query,
  input  logic            ctl_modify,
  input  logic [WW-1:0]   ctl_word,
  input  logic [DW-1:0]   ctl_wdata,
  output logic [DW-1:0]   ctl_rdata,
  output logic            ctl_rvalid,
  input  logic            tdef_wr,
  input  logic [WW-1:0]   tdef_word,
  input  logic [DW-1:0]   tdef_data,
  output logic            tdef_reject,
  input  logic            ddef_wr,
  input  logic [WW-1:0]   ddef_word,
  input  logic [DW-1:0]   ddef_data,
  output logic            wr_event
);

  logic [DW-1:0] live_q [WORDS];
  logic [DW-1:0] dact_q [WORDS];
  logic [DW-1:0] dpend_q[WORDS];
  logic [DW-1:0] tdef_q [WORDS];

  logic [WORDS-1:0] live_v, dact_v, dpend_v, tdef_v, dirty;
  logic [WORDS-1:0] live_v_n, dirty_n;

  logic [WW-1:0] hw;
  logic [DW-1:0] h_cur, c_cur, h_merged;
  logic          collide, tdef_ok;

  assign hw      = host_addr[AW-1:LSB];
  assign collide = host_wr && ctl_modify && (hw == ctl_word);
  assign tdef_ok = tdef_wr && !dev_present;

  assign h_cur = live_v[hw] ? live_q[hw] :
                 dact_v[hw] ? dact_q[hw] :
                 tdef_v[hw] ? tdef_q[hw] : '0;

  assign c_cur = live_v[ctl_word] ? live_q[ctl_word] :
                 dact_v[ctl_word] ? dact_q[ctl_word] :
                 tdef_v[ctl_word] ? tdef_q[ctl_word] : '0;

  for (genvar b = 0; b < BE_W; b++) begin : g_merge
    assign h_merged[8*b +: 8] = host_be[b] ? host_wdata[8*b +: 8] : h_cur[8*b +: 8];
  end

  always_comb begin
    live_v_n = live_v;
    dirty_n  = dirty;
    if (ctl_query || ctl_modify) dirty_n[ctl_word] = 1'b0;
    if (ctl_modify)              live_v_n[ctl_word] = 1'b1;
    if (host_wr) begin
      dirty_n[hw]  = 1'b1;
      live_v_n[hw] = 1'b1;
    end
    if (flr) begin
      live_v_n = '0;
      dirty_n  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_v      <= '0;
      dirty       <= '0;
      dact_v      <= '0;
      dpend_v     <= '0;
      tdef_v      <= '0;
      host_rvalid <= 1'b0;
      ctl_rvalid  <= 1'b0;
      tdef_reject <= 1'b0;
    end else begin
      live_v      <= live_v_n;
      dirty       <= dirty_n;
      host_rvalid <= host_rd;
      ctl_rvalid  <= ctl_query;
      tdef_reject <= tdef_wr && dev_present;
      if (tdef_ok) tdef_v[tdef_word]  <= 1'b1;
      if (ddef_wr) dpend_v[ddef_word] <= 1'b1;
      if (flr)     dact_v <= dpend_v;
    end
  end

  always_ff @(posedge clk) begin
    if (ctl_modify && !collide) live_q[ctl_word] <= ctl_wdata;
    if (host_wr)  live_q[hw]         <= h_merged;
    if (tdef_ok)  tdef_q[tdef_word]  <= tdef_data;
    if (ddef_wr)  dpend_q[ddef_word] <= ddef_data;
    if (flr)      dact_q <= dpend_q;
    if (host_rd)   host_rdata <= h_cur;
    if (ctl_query) ctl_rdata  <= c_cur;
  end

  assign wr_event = |dirty;

  // R4
  evt_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !flr) |=> wr_event);

  // R9
  flr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flr |=> !wr_event);

  // R2
  rd_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd |=> host_rvalid);

  // R5
  q_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_query |=> ctl_rvalid);

  // R10
  rej_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tdef_wr && dev_present) |=> tdef_reject);

  // R10
  no_rej_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tdef_wr |=> !tdef_reject);

  // R2
  raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && (&host_be) && !flr) ##1 (host_rd && host_addr == $past(host_addr))
      |=> host_rdata == $past(host_wdata, 2));

endmodule

// File: tb/sim_stateful_bar_region.sv
module sim_stateful_bar_region;
  logic        clk = 1'b0;
  logic        rst_n, flr, dev_present;
  logic        host_wr, host_rd;
  logic [7:0]  host_addr;
  logic [3:0]  host_be;
  logic [31:0] host_wdata, host_rdata;
  logic        host_rvalid;
  logic        ctl_query, ctl_modify;
  logic [5:0]  ctl_word;
  logic [31:0] ctl_wdata, ctl_rdata;
  logic        ctl_rvalid;
  logic        tdef_wr;
  logic [5:0]  tdef_word;
  logic [31:0] tdef_data;
  logic        tdef_reject;
  logic        ddef_wr;
  logic [5:0]  ddef_word;
  logic [31:0] ddef_data;
  logic        wr_event;

  int checks = 0, fails = 0;
  logic [31:0] hexp[$], cexp[$];
  string       htag[$], ctag[$];

  always #10 clk = ~clk;

  stateful_bar_region u0 (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && host_rvalid) begin
      if (hexp.size() == 0) check("host read unexpected", 32'h1, 32'h0);
      else check(htag.pop_front(), host_rdata, hexp.pop_front());
    end
    if (rst_n && ctl_rvalid) begin
      if (cexp.size() == 0) check("ctl read unexpected", 32'h1, 32'h0);
      else check(ctag.pop_front(), ctl_rdata, cexp.pop_front());
    end
  end

  task automatic hwrite(logic [7:0] a, logic [3:0] be, logic [31:0] d);
    host_wr = 1'b1; host_addr = a; host_be = be; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hread(logic [7:0] a, logic [31:0] exp, string tag);
    hexp.push_back(exp); htag.push_back(tag);
    host_rd = 1'b1; host_addr = a;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic dquery(logic [5:0] w, logic [31:0] exp, string tag);
    cexp.push_back(exp); ctag.push_back(tag);
    ctl_query = 1'b1; ctl_word = w;
    @(negedge clk);
    ctl_query = 1'b0;
  endtask

  task automatic dmod(logic [5:0] w, logic [31:0] d);
    ctl_modify = 1'b1; ctl_word = w; ctl_wdata = d;
    @(negedge clk);
    ctl_modify = 1'b0;
  endtask

  task automatic tdef(logic [5:0] w, logic [31:0] d);
    tdef_wr = 1'b1; tdef_word = w; tdef_data = d;
    @(negedge clk);
    tdef_wr = 1'b0;
  endtask

  task automatic ddef(logic [5:0] w, logic [31:0] d);
    ddef_wr = 1'b1; ddef_word = w; ddef_data = d;
    @(negedge clk);
    ddef_wr = 1'b0;
  endtask

  task automatic pulse_flr();
    flr = 1'b1;
    @(negedge clk);
    flr = 1'b0;
  endtask

  initial begin
    #(20ns * 100000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; flr = 1'b0; dev_present = 1'b0;
    host_wr = 1'b0; host_rd = 1'b0; host_addr = '0; host_be = '0; host_wdata = '0;
    ctl_query = 1'b0; ctl_modify = 1'b0; ctl_word = '0; ctl_wdata = '0;
    tdef_wr = 1'b0; tdef_word = '0; tdef_data = '0;
    ddef_wr = 1'b0; ddef_word = '0; ddef_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    check("R1 event after reset", {31'b0, wr_event}, 32'h0);
    check("R1 reject after reset", {31'b0, tdef_reject}, 32'h0);
    hread(8'h00, 32'h0, "R1 word0 zero");
    hread(8'h3C, 32'h0, "R1 word15 zero");

    tdef(6'd1, 32'h1111_1111);
    hread(8'h04, 32'h1111_1111, "R7 type default");
    ddef(6'd1, 32'h2222_2222);
    hread(8'h04, 32'h1111_1111, "R8 staged default hidden");
    pulse_flr();
    hread(8'h04, 32'h2222_2222, "R8 default active after flr");

    hwrite(8'h04, 4'hF, 32'hAABB_CCDD);
    check("R4 event raised", {31'b0, wr_event}, 32'h1);
    hread(8'h04, 32'hAABB_CCDD, "R2 read after write");
    hwrite(8'h08, 4'h3, 32'h1234_5678);
    hwrite(8'h04, 4'h4, 32'h00EE_0000);
    hread(8'h08, 32'h0000_5678, "R3 partial over zero");
    hread(8'h04, 32'hAAEE_CCDD, "R3 partial over written");

    dquery(6'd1, 32'hAAEE_CCDD, "R5 query value");
    check("R5 event still pending", {31'b0, wr_event}, 32'h1);
    dquery(6'd2, 32'h0000_5678, "R5 query second");
    check("R5 event cleared", {31'b0, wr_event}, 32'h0);

    hwrite(8'h0C, 4'hF, 32'h0000_0033);
    check("R4 event again", {31'b0, wr_event}, 32'h1);
    dmod(6'd3, 32'h4444_4444);
    check("R6 modify clears event", {31'b0, wr_event}, 32'h0);
    hread(8'h0C, 32'h4444_4444, "R6 host sees modify");

    dev_present = 1'b1;
    tdef(6'd5, 32'h5555_5555);
    check("R10 reject pulse", {31'b0, tdef_reject}, 32'h1);
    hread(8'h14, 32'h0, "R10 rejected write ignored");
    dev_present = 1'b0;
    tdef(6'd5, 32'h6666_6666);
    check("R10 no reject", {31'b0, tdef_reject}, 32'h0);
    hread(8'h14, 32'h6666_6666, "R10 accepted write");

    host_wr = 1'b1; host_addr = 8'h18; host_be = 4'hF; host_wdata = 32'h7777_7777;
    ctl_modify = 1'b1; ctl_word = 6'd6; ctl_wdata = 32'h8888_8888;
    @(negedge clk);
    host_wr = 1'b0; ctl_modify = 1'b0;
    check("R11 collision keeps dirty", {31'b0, wr_event}, 32'h1);
    hread(8'h18, 32'h7777_7777, "R11 host wins");

    hwrite(8'hFC, 4'hF, 32'hCAFE_F00D);
    hread(8'hFC, 32'hCAFE_F00D, "R2 last word");

    pulse_flr();
    check("R9 flr clears event", {31'b0, wr_event}, 32'h0);
    hread(8'h04, 32'h2222_2222, "R9 device default after flr");
    hread(8'h08, 32'h0, "R9 written value discarded");
    hread(8'h14, 32'h6666_6666, "R9 type default kept");
    dquery(6'd63, 32'h0, "R7 zero layer");

    repeat (3) @(negedge clk);
    check("queues drained", hexp.size() + cexp.size(), 32'h0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule